// File: doc/BRIEF.md
# Hardware Thread Run-State Controller

This block keeps the run state of up to `NT` hardware thread contexts in a multithreaded in-order core. It takes commands that start, stop, park or retire a thread, each tagged with a thread id. From these it maintains an ordered list of running threads and a first-in first-out queue of threads that wait to run. The head of the running list is the thread that gets priority this cycle. The list rotates one place at the end of every cycle in which more than one thread runs, which gives round-robin fairness by default.

A static configuration input selects the threading model. In single-thread mode only thread 0 may run. In simultaneous mode every started thread runs at once. In switch-on-miss mode at most one thread runs. Further start requests queue up, and retiring the running thread promotes the oldest queued one. When a thread leaves the running list, the block sends a one-cycle stall-release pulse for it to every pipeline stage. When a thread is retired (halted), it sends a squash pulse to every stage. Two cycle counters report how long each thread has run and how long more than one thread has run at the same time.

Top module: `thread_act_ctrl`

## Requirements
- R1: After reset every thread is idle (state code 0), no thread runs, `prio_v_o`, all pulses and `next_err_o` are 0 and all counters are 0. Thread t's state sits at `state_o[3t+2:3t]`: 0 idle, 1 running, 2 queued, 3 parked, 4 retired.
- R2: A start for an idle, parked or retired thread appends it to the tail of the running list (state 1), unless R4 or R10 applies. A start for a running or queued thread has no effect. `active_o[t]` is 1 exactly when thread t is running.
- R3: `prio_tid_o` is the head of the running list and `prio_v_o` is 1 when the list is non-empty. At the end of every cycle with two or more running threads, the head moves to the tail.
- R4: In switch-on-miss mode (`model_i`=2), a start that finds exactly one thread running appends the thread to the tail of the wait queue (state 2) and does not start it.
- R5: A stop moves a running thread to idle, removes it from the list and raises `stall_clr_o[s*NT+t]` for every stage s in the next cycle. A stop for a queued thread removes it from the queue and makes it idle. A stop for a thread in any other state has no effect.
- R6: A halt makes the thread retired (state 4) and raises `squash_o[s*NT+t]` for every stage s. If the thread was running, it also does what R5 does for a running thread. If it was queued, it leaves the queue. In switch-on-miss mode a halt also requests promote-next (R8).
- R7: A park makes the thread parked (state 3). A running thread gets the stall-release pulse of R5 and a queued thread leaves the queue.
- R8: Promote-next, requested by `next_v_i` or by R6, pops the oldest queued thread and appends it to the running list. If the queue is empty, `next_err_o` pulses for one cycle instead. Two requests in one cycle pop only one thread.
- R9: Commands that arrive in the same cycle take effect in the order stop, halt, park, start, promote-next, and the R3 rotation comes last. Each command sees the result of the ones before it.
- R10: In single-thread mode (`model_i`=0, or `NT`=1) a start for any thread other than 0 is ignored. A `model_i` of 3 behaves as simultaneous mode.
- R11: Each cycle `act_cyc_o[t*CW +: CW]` increments when thread t ran in the previous cycle, and `multi_cyc_o` increments when two or more threads ran.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| model_i | input | 2 | Threading model: 0 single, 1 simultaneous, 2 switch-on-miss, 3 simultaneous |
| deact_v_i | input | 1 | Stop command valid |
| deact_tid_i | input | TW | Stop target thread |
| halt_v_i | input | 1 | Halt command valid |
| halt_tid_i | input | TW | Halt target thread |
| susp_v_i | input | 1 | Park command valid |
| susp_tid_i | input | TW | Park target thread |
| act_v_i | input | 1 | Start command valid |
| act_tid_i | input | TW | Start target thread |
| next_v_i | input | 1 | Promote-next request |
| active_o | output | NT | Running mask, one bit per thread |
| prio_v_o | output | 1 | Some thread is running |
| prio_tid_o | output | TW | Highest-priority running thread |
| state_o | output | 3*NT | Per-thread state codes |
| stall_clr_o | output | STAGES*NT | Stall-release pulses, per stage and thread |
| squash_o | output | STAGES*NT | Squash pulses, per stage and thread |
| next_err_o | output | 1 | Promote-next found the wait queue empty |
| act_cyc_o | output | NT*CW | Per-thread running-cycle counters |
| multi_cyc_o | output | CW | Counter of cycles with two or more threads running |

## Verification
The bench aims at same-cycle command mixes. A design that applied start before stop would refuse to start a thread in switch-on-miss mode when the running thread leaves in the same cycle. One that ran promote-next early would report an empty queue that a start had just filled. It checks that a halt in switch-on-miss mode promotes the oldest queued thread, and that a second start of a queued thread is not queued twice. A duplicate queue entry would later surface as a spurious promotion. It also drives stops and halts at queued threads, whose queue entries must disappear. It confirms that the rotation uses the final list of the cycle and not the list at the cycle's start, which a wrong design would expose as a wrong `prio_tid_o` after every start or stop.

// File: rtl/tac_pkg.sv
package tac_pkg;
    typedef enum logic [2:0] {
        TS_IDLE  = 3'd0,
        TS_RUN   = 3'd1,
        TS_READY = 3'd2,
        TS_SUSP  = 3'd3,
        TS_HALT  = 3'd4
    } tstate_e;
endpackage

// File: rtl/tac_fanout.sv
// Replicates a per-thread pulse mask to every pipeline stage.
module tac_fanout #(
    parameter int NT     = 4,
    parameter int STAGES = 5
) (
    input  logic [NT-1:0]        mask_i,
    output logic [STAGES*NT-1:0] fan_o
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign fan_o[s*NT +: NT] = mask_i;
    end
endmodule

// File: rtl/tac_counters.sv
// Per-thread running-cycle counters and a multi-thread cycle counter.
module tac_counters #(
    parameter int NT = 4,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    run_i,
    output logic [NT*CW-1:0] act_cyc_o,
    output logic [CW-1:0]    multi_cyc_o
);
    typedef struct packed {
        logic [NT-1:0][CW-1:0] per;
        logic [CW-1:0]         multi;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int t = 0; t < NT; t++) begin
            if (run_i[t]) cnt_d.per[t] = cnt_q.per[t] + 1'b1;
        end
        if ($countones(run_i) > 1) cnt_d.multi = cnt_q.multi + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign act_cyc_o   = cnt_q.per;
    assign multi_cyc_o = cnt_q.multi;
endmodule

// File: rtl/thread_act_ctrl.sv
module thread_act_ctrl
    import tac_pkg::*;
#(
    parameter int NT     = 4,
    parameter int STAGES = 5,
    parameter int CW     = 16,
    localparam int TW    = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           model_i,
    input  logic                 deact_v_i,
    input  logic [TW-1:0]        deact_tid_i,
    input  logic                 halt_v_i,
    input  logic [TW-1:0]        halt_tid_i,
    input  logic                 susp_v_i,
    input  logic [TW-1:0]        susp_tid_i,
    input  logic                 act_v_i,
    input  logic [TW-1:0]        act_tid_i,
    input  logic                 next_v_i,
    output logic [NT-1:0]        active_o,
    output logic                 prio_v_o,
    output logic [TW-1:0]        prio_tid_o,
    output logic [3*NT-1:0]      state_o,
    output logic [STAGES*NT-1:0] stall_clr_o,
    output logic [STAGES*NT-1:0] squash_o,
    output logic                 next_err_o,
    output logic [NT*CW-1:0]     act_cyc_o,
    output logic [CW-1:0]        multi_cyc_o
);
    localparam int CNTW = $clog2(NT + 1);

    // Ordered thread-id list: entries [0 .. n-1] are valid, entry 0 is the head.
    typedef struct packed {
        logic [NT-1:0][TW-1:0] e;
        logic [CNTW-1:0]       n;
    } seq_t;

    typedef struct packed {
        seq_t                run;
        seq_t                rdy;
        tstate_e [NT-1:0]    st;
        logic [NT-1:0]       stall_clr;
        logic [NT-1:0]       squash;
        logic                err;
    } reg_t;

    reg_t r_d, r_q;
    logic is_single, is_socm;

    function automatic seq_t f_remove(seq_t s, logic [TW-1:0] t);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NT - 1; i++) begin
            if (!hit && i < int'(s.n) && s.e[i] == t) hit = 1'b1;
            if (hit) s.e[i] = s.e[i+1];
        end
        if (!hit && (NT - 1) < int'(s.n) && s.e[NT-1] == t) hit = 1'b1;
        if (hit) s.n = s.n - 1'b1;
        return s;
    endfunction

    function automatic seq_t f_push(seq_t s, logic [TW-1:0] t);
        if (int'(s.n) < NT) begin
            for (int i = 0; i < NT; i++) begin
                if (i == int'(s.n)) s.e[i] = t;
            end
            s.n = s.n + 1'b1;
        end
        return s;
    endfunction

    function automatic seq_t f_pop(seq_t s);
        for (int i = 0; i < NT - 1; i++) s.e[i] = s.e[i+1];
        s.n = s.n - 1'b1;
        return s;
    endfunction

    function automatic seq_t f_rotate(seq_t s);
        logic [TW-1:0] h;
        h = s.e[0];
        if (int'(s.n) > 1) begin
            for (int i = 0; i < NT - 1; i++) begin
                if (i + 1 < int'(s.n)) s.e[i] = s.e[i+1];
            end
            for (int i = 0; i < NT; i++) begin
                if (i == int'(s.n) - 1) s.e[i] = h;
            end
        end
        return s;
    endfunction

    // Leave the running list or the wait queue, whichever holds the thread.
    function automatic reg_t f_leave(reg_t r, logic [TW-1:0] t);
        if (r.st[t] == TS_RUN) begin
            r.run          = f_remove(r.run, t);
            r.stall_clr[t] = 1'b1;
        end else if (r.st[t] == TS_READY) begin
            r.rdy = f_remove(r.rdy, t);
        end
        return r;
    endfunction

    always_comb begin
        is_single = (NT == 1) || (model_i == 2'd0);
        is_socm   = (NT > 1) && (model_i == 2'd2);
    end

    always_comb begin
        logic          want_next;
        logic [TW-1:0] pt;
        r_d           = r_q;
        r_d.stall_clr = '0;
        r_d.squash    = '0;
        r_d.err       = 1'b0;
        want_next     = next_v_i;
        pt            = '0;

        // R9: fixed order stop, halt, park, start, promote-next, rotate
        if (deact_v_i && int'(deact_tid_i) < NT) begin
            if (r_d.st[deact_tid_i] == TS_RUN || r_d.st[deact_tid_i] == TS_READY) begin
                r_d                 = f_leave(r_d, deact_tid_i);
                r_d.st[deact_tid_i] = TS_IDLE;
            end
        end
        if (halt_v_i && int'(halt_tid_i) < NT) begin
            r_d                    = f_leave(r_d, halt_tid_i);
            r_d.st[halt_tid_i]     = TS_HALT;
            r_d.squash[halt_tid_i] = 1'b1;
            if (is_socm) want_next = 1'b1;
        end
        if (susp_v_i && int'(susp_tid_i) < NT) begin
            r_d                = f_leave(r_d, susp_tid_i);
            r_d.st[susp_tid_i] = TS_SUSP;
        end
        if (act_v_i && int'(act_tid_i) < NT && !(is_single && act_tid_i != '0)) begin
            if (r_d.st[act_tid_i] != TS_RUN && r_d.st[act_tid_i] != TS_READY) begin
                if (is_socm && int'(r_d.run.n) == 1) begin
                    r_d.rdy               = f_push(r_d.rdy, act_tid_i);
                    r_d.st[act_tid_i]     = TS_READY;
                end else begin
                    r_d.run               = f_push(r_d.run, act_tid_i);
                    r_d.st[act_tid_i]     = TS_RUN;
                end
            end
        end
        if (want_next) begin
            if (r_d.rdy.n != '0) begin
                pt         = r_d.rdy.e[0];
                r_d.rdy    = f_pop(r_d.rdy);
                r_d.run    = f_push(r_d.run, pt);
                r_d.st[pt] = TS_RUN;
            end else begin
                r_d.err = 1'b1;
            end
        end
        r_d.run = f_rotate(r_d.run);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign active_o[t]        = (r_q.st[t] == TS_RUN);
        assign state_o[3*t +: 3]  = r_q.st[t];
    end

    assign prio_v_o   = (r_q.run.n != '0);
    assign prio_tid_o = r_q.run.e[0];
    assign next_err_o = r_q.err;

    tac_fanout #(.NT(NT), .STAGES(STAGES)) u_stall_fan (
        .mask_i (r_q.stall_clr),
        .fan_o  (stall_clr_o)
    );

    tac_fanout #(.NT(NT), .STAGES(STAGES)) u_squash_fan (
        .mask_i (r_q.squash),
        .fan_o  (squash_o)
    );

    tac_counters #(.NT(NT), .CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (active_o),
        .act_cyc_o   (act_cyc_o),
        .multi_cyc_o (multi_cyc_o)
    );
endmodule

// File: rtl/tac_chk.sv
module tac_chk #(
    parameter int NT     = 4,
    parameter int STAGES = 5,
    parameter int CW     = 16,
    parameter int TW     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           model_i,
    input logic                 deact_v_i,
    input logic                 halt_v_i,
    input logic [TW-1:0]        halt_tid_i,
    input logic                 susp_v_i,
    input logic                 act_v_i,
    input logic                 next_v_i,
    input logic [NT-1:0]        active_o,
    input logic                 prio_v_o,
    input logic [TW-1:0]        prio_tid_o,
    input logic [3*NT-1:0]      state_o,
    input logic [STAGES*NT-1:0] stall_clr_o,
    input logic [STAGES*NT-1:0] squash_o,
    input logic                 next_err_o,
    input logic [NT*CW-1:0]     act_cyc_o
);
    logic quiet;
    logic any_ready;
    assign quiet = !(deact_v_i || halt_v_i || susp_v_i || act_v_i || next_v_i);

    always_comb begin
        any_ready = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (state_o[3*t +: 3] == 3'd2) any_ready = 1'b1;
        end
    end

    AST_PRIO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        prio_v_o == (active_o != '0)); // R3
    AST_PRIO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        prio_v_o |-> active_o[prio_tid_o]); // R3
    AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && $countones(active_o) > 1) |=> prio_tid_o != $past(prio_tid_o)); // R3
    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        next_err_o |-> !any_ready); // R8

    for (genvar t = 0; t < NT; t++) begin : g_t
        AST_STALL_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            active_o[t] |=> (active_o[t] || stall_clr_o[t])); // R5
        AST_SQUASH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            squash_o[t] |-> $past(halt_v_i && int'(halt_tid_i) == t)); // R6
        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> act_cyc_o[t*CW +: CW] ==
                     $past(act_cyc_o[t*CW +: CW]) + CW'($past(active_o[t]))); // R11
    end

    if (NT > 1) begin : g_single
        AST_SINGLE_ONLY0: assert property (@(posedge clk) disable iff (!rst_n)
            (model_i == 2'd0) |-> active_o[NT-1:1] == '0); // R10
    end
endmodule

bind thread_act_ctrl tac_chk #(.NT(NT), .STAGES(STAGES), .CW(CW), .TW(TW)) u_tac_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .model_i     (model_i),
    .deact_v_i   (deact_v_i),
    .halt_v_i    (halt_v_i),
    .halt_tid_i  (halt_tid_i),
    .susp_v_i    (susp_v_i),
    .act_v_i     (act_v_i),
    .next_v_i    (next_v_i),
    .active_o    (active_o),
    .prio_v_o    (prio_v_o),
    .prio_tid_o  (prio_tid_o),
    .state_o     (state_o),
    .stall_clr_o (stall_clr_o),
    .squash_o    (squash_o),
    .next_err_o  (next_err_o),
    .act_cyc_o   (act_cyc_o)
);

// File: tb/thread_act_ctrl_bench.sv
module thread_act_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int STAGES = 5;
    localparam int CW = 16;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] model_i = 2'd1;
    logic deact_v_i = 0, halt_v_i = 0, susp_v_i = 0, act_v_i = 0, next_v_i = 0;
    logic [TW-1:0] deact_tid_i = 0, halt_tid_i = 0, susp_tid_i = 0, act_tid_i = 0;
    logic [NT-1:0] active_o;
    logic prio_v_o;
    logic [TW-1:0] prio_tid_o;
    logic [3*NT-1:0] state_o;
    logic [STAGES*NT-1:0] stall_clr_o, squash_o;
    logic next_err_o;
    logic [NT*CW-1:0] act_cyc_o;
    logic [CW-1:0] multi_cyc_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_act_ctrl #(.NT(NT), .STAGES(STAGES), .CW(CW)) u_thread_act_ctrl (
        .clk(clk), .rst_n(rst_n), .model_i(model_i),
        .deact_v_i(deact_v_i), .deact_tid_i(deact_tid_i),
        .halt_v_i(halt_v_i), .halt_tid_i(halt_tid_i),
        .susp_v_i(susp_v_i), .susp_tid_i(susp_tid_i),
        .act_v_i(act_v_i), .act_tid_i(act_tid_i), .next_v_i(next_v_i),
        .active_o(active_o), .prio_v_o(prio_v_o), .prio_tid_o(prio_tid_o),
        .state_o(state_o), .stall_clr_o(stall_clr_o), .squash_o(squash_o),
        .next_err_o(next_err_o), .act_cyc_o(act_cyc_o), .multi_cyc_o(multi_cyc_o)
    );

    // Reference model state
    int m_st[NT];
    int m_al[NT];
    int m_an;
    int m_rf[NT];
    int m_rn;
    bit e_stall[NT];
    bit e_sq[NT];
    bit e_err;
    int m_cnt[NT];
    int m_multi;

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void m_clear();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_al[t] = 0; m_rf[t] = 0;
            e_stall[t] = 0; e_sq[t] = 0; m_cnt[t] = 0;
        end
        m_an = 0; m_rn = 0; e_err = 0; m_multi = 0;
    endfunction

    function automatic void run_remove(int t);
        for (int i = 0; i < m_an; i++) begin
            if (m_al[i] == t) begin
                for (int j = i; j < m_an - 1; j++) m_al[j] = m_al[j+1];
                m_an--;
                return;
            end
        end
    endfunction

    function automatic void rdy_remove(int t);
        for (int i = 0; i < m_rn; i++) begin
            if (m_rf[i] == t) begin
                for (int j = i; j < m_rn - 1; j++) m_rf[j] = m_rf[j+1];
                m_rn--;
                return;
            end
        end
    endfunction

    function automatic void leave(int t);
        if (m_st[t] == 1) begin
            run_remove(t);
            e_stall[t] = 1;
        end else if (m_st[t] == 2) begin
            rdy_remove(t);
        end
    endfunction

    // One clock of the requirements, applied to the model.
    function automatic void m_step(int mdl, bit dv, int dt, bit hv, int ht,
                                   bit sv, int stt, bit av, int at, bit nv);
        bit want;
        int h;
        for (int t = 0; t < NT; t++) if (m_st[t] == 1) m_cnt[t]++;
        if (m_an > 1) m_multi++;
        for (int t = 0; t < NT; t++) begin e_stall[t] = 0; e_sq[t] = 0; end
        e_err = 0;
        if (mdl == 3) mdl = 1;
        want = nv;
        if (dv && (m_st[dt] == 1 || m_st[dt] == 2)) begin
            leave(dt); m_st[dt] = 0;
        end
        if (hv) begin
            leave(ht); m_st[ht] = 4; e_sq[ht] = 1;
            if (mdl == 2) want = 1;
        end
        if (sv) begin
            leave(stt); m_st[stt] = 3;
        end
        if (av && !(mdl == 0 && at != 0) && m_st[at] != 1 && m_st[at] != 2) begin
            if (mdl == 2 && m_an == 1) begin
                m_rf[m_rn] = at; m_rn++; m_st[at] = 2;
            end else begin
                m_al[m_an] = at; m_an++; m_st[at] = 1;
            end
        end
        if (want) begin
            if (m_rn > 0) begin
                h = m_rf[0];
                for (int j = 0; j < m_rn - 1; j++) m_rf[j] = m_rf[j+1];
                m_rn--;
                m_al[m_an] = h; m_an++; m_st[h] = 1;
            end else begin
                e_err = 1;
            end
        end
        if (m_an > 1) begin
            h = m_al[0];
            for (int j = 0; j < m_an - 1; j++) m_al[j] = m_al[j+1];
            m_al[m_an-1] = h;
        end
    endfunction

    task automatic compare_all();
        logic [NT-1:0] ea;
        logic [3*NT-1:0] es;
        logic [STAGES*NT-1:0] estall, esq;
        logic [NT*CW-1:0] ec;
        for (int t = 0; t < NT; t++) begin
            ea[t] = (m_st[t] == 1);
            es[3*t +: 3] = 3'(m_st[t]);
            ec[t*CW +: CW] = CW'(m_cnt[t]);
            for (int s = 0; s < STAGES; s++) begin
                estall[s*NT+t] = e_stall[t];
                esq[s*NT+t] = e_sq[t];
            end
        end
        chk("R2 active_o", active_o, ea);
        chk("R2 state_o", state_o, es);
        chk("R3 prio_v_o", prio_v_o, m_an > 0);
        if (m_an > 0) chk("R3 prio_tid_o", prio_tid_o, m_al[0]);
        chk("R5 stall_clr_o", stall_clr_o, estall);
        chk("R6 squash_o", squash_o, esq);
        chk("R8 next_err_o", next_err_o, e_err);
        chk("R11 act_cyc_o", act_cyc_o, ec);
        chk("R11 multi_cyc_o", multi_cyc_o, CW'(m_multi));
    endtask

    task automatic step(bit dv, int dt, bit hv, int ht, bit sv, int stt,
                        bit av, int at, bit nv);
        deact_v_i = dv; deact_tid_i = TW'(dt);
        halt_v_i = hv; halt_tid_i = TW'(ht);
        susp_v_i = sv; susp_tid_i = TW'(stt);
        act_v_i = av; act_tid_i = TW'(at);
        next_v_i = nv;
        m_step(int'(model_i), dv, dt, hv, ht, sv, stt, av, at, nv);
        @(posedge clk);
        @(negedge clk);
        deact_v_i = 0; halt_v_i = 0; susp_v_i = 0; act_v_i = 0; next_v_i = 0;
        compare_all();
    endtask

    task automatic do_reset(input logic [1:0] mdl);
        @(negedge clk);
        rst_n = 0;
        model_i = mdl;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed1234));
        // R1: reset state
        do_reset(2'd1);
        chk("R1 active_o", active_o, 0);
        chk("R1 state_o", state_o, 0);
        chk("R1 prio_v_o", prio_v_o, 0);
        chk("R1 next_err_o", next_err_o, 0);
        chk("R1 act_cyc_o", act_cyc_o, 0);
        chk("R1 multi_cyc_o", multi_cyc_o, 0);
        chk("R1 stall_clr_o", stall_clr_o | squash_o, 0);

        // Simultaneous mode: append order and rotation
        step(0,0,0,0,0,0,1,0,0);
        step(0,0,0,0,0,0,1,1,0);   // list [1,0]
        step(0,0,0,0,0,0,1,2,0);   // list [0,2,1]
        step(0,0,0,0,0,0,0,0,0);   // [2,1,0]
        chk("R3 rotate head", prio_tid_o, 2);
        step(0,0,0,0,0,0,0,0,0);   // [1,0,2]
        chk("R3 rotate head", prio_tid_o, 1);
        step(0,0,0,0,0,0,1,1,0);   // restart of running thread: no effect
        chk("R2 restart ignored", active_o, 4'b0111);
        chk("R3 rotate head", prio_tid_o, 0);

        // Switch-on-miss mode
        do_reset(2'd2);
        step(0,0,0,0,0,0,1,1,0);
        step(0,0,0,0,0,0,1,2,0);
        chk("R4 queued state", state_o[8:6], 3'd2);
        chk("R4 not started", active_o, 4'b0010);
        step(0,0,0,0,0,0,1,2,0);   // second start of queued thread: no effect
        step(0,0,1,1,0,0,0,0,0);   // halt 1 promotes 2
        chk("R6 promoted", active_o, 4'b0100);
        chk("R6 halted state", state_o[5:3], 3'd4);
        chk("R6 squash pulse", squash_o[NT-1:0], 4'b0010);
        step(0,0,0,0,0,0,0,0,1);
        chk("R8 empty queue error", next_err_o, 1);
        step(0,0,0,0,0,0,1,3,0);   // 3 queued
        step(1,2,0,0,0,0,1,0,1);   // stop 2, start 0, promote 3
        chk("R9 same-cycle order", active_o, 4'b1001);
        step(0,0,0,0,1,0,0,0,0);
        chk("R7 parked state", state_o[2:0], 3'd3);
        chk("R7 stall pulse", stall_clr_o[NT-1:0], 4'b0001);
        step(0,0,0,0,0,0,1,0,0);   // one running: 0 queued
        step(1,0,0,0,0,0,0,0,0);
        chk("R5 queued stop idle", state_o[2:0], 3'd0);
        step(0,0,0,0,0,0,0,0,1);
        chk("R5 queue emptied", next_err_o, 1);

        // Single mode
        do_reset(2'd0);
        step(0,0,0,0,0,0,1,2,0);
        chk("R10 other thread ignored", active_o, 4'b0000);
        step(0,0,0,0,0,0,1,0,0);
        chk("R10 thread 0 runs", active_o, 4'b0001);

        // Random phases across all models
        for (int p = 0; p < 4; p++) begin
            do_reset(2'(p == 0 ? 1 : p == 1 ? 2 : p == 2 ? 0 : 3));
            for (int k = 0; k < 600; k++) begin
                step(($urandom % 5) == 0, int'($urandom % NT),
                     ($urandom % 8) == 0, int'($urandom % NT),
                     ($urandom % 8) == 0, int'($urandom % NT),
                     ($urandom % 3) == 0, int'($urandom % NT),
                     ($urandom % 7) == 0);
            end
        end
        finish_run();
    end
endmodule